// File: doc/BRIEF.md
# Regulator Channel Control Supervisor

This block is the digital supervisor for a single channel of a multi-channel switching-regulator controller. It keeps an 8-bit read/write configuration register on a simple register bus. From that register and from the start-up sequencer it works out whether the channel runs. It also drives the phase-select and scaling-rate outputs, the active-low interrupt and the output-discharge enable.

The channel-on decision has two sources. By default the channel follows the sequencer status. When the override control bit is set, the register's own enable bit decides, whatever the sequencer says.

A short circuit seen while the channel runs is handled by one of two policies, chosen by a register bit. In the local policy the channel alone drops for a programmable off-time and then requests a soft start, and this repeats for as long as the short persists. In the global policy the block requests a shutdown of all channels, holds it for a programmable delay (about 100 ms in silicon), and then strobes a restart of the whole sequence. Each detected short sets a sticky fault flag. The flag can be read on a second address and drives the interrupt unless it is masked.

Top module: `chan_ctl_sup`

## Requirements
- R1: After reset the configuration register at address 0x45 reads 0xA0, the status register at 0x46 reads 0x00, irq_n is 1 and no shutdown, restart or soft-start output is active.
- R2: All eight configuration bits are written and read back at 0x45. A write to any other address leaves the configuration unchanged.
- R3: With bit 0 (override control) at 0, chan_en follows seq_en and bit 1 has no effect. With bit 0 at 1, chan_en equals bit 1 regardless of seq_en.
- R4: phase_sel equals configuration bit 4 (1 = opposite phase to the oscillator), and rate_code equals bits 3:2.
- R5: dischg_en is 1 exactly when configuration bit 5 is 1 and chan_en is 0.
- R6: A detected short circuit sets a sticky fault flag, read as bit 0 of the status register. A read of the status register clears it, and so does a write to the configuration register. Status bits 7:1 hold the retry count, zero-extended.
- R7: irq_n is 0 while the fault flag is 1 and configuration bit 7 (mask) is 0. With the mask at 1, irq_n stays 1 but the flag is still recorded.
- R8: With bit 6 at 1, a short circuit turns the channel off for OFF_CYC cycles. The channel then comes back with a one-cycle softstart_req pulse, and retry_cnt goes up by one. glob_shdn is not asserted.
- R9: Local retries repeat for as long as the short persists, with no limit. retry_cnt saturates at its maximum value.
- R10: With bit 6 at 0, a short circuit asserts glob_shdn and holds the channel off for RESTART_CYC cycles. A one-cycle restart_req pulse follows. Short-circuit input during the shutdown is ignored.
- R11: A short circuit is detected only while the channel is enabled. With the channel off, sc_in sets no flag and starts no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears fault flag on status reads) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address |
| seq_en | input | 1 | Enable status from the start-up sequencer |
| sc_in | input | 1 | Short-circuit indication for this channel |
| chan_en | output | 1 | Channel enable to the regulator |
| dischg_en | output | 1 | Active output discharge enable |
| phase_sel | output | 1 | Phase selection relative to the oscillator |
| rate_code | output | 2 | Voltage-scaling rate code |
| irq_n | output | 1 | Active-low interrupt |
| glob_shdn | output | 1 | All-channel shutdown request |
| restart_req | output | 1 | One-cycle sequence restart strobe |
| softstart_req | output | 1 | One-cycle soft-start request after a local retry |
| retry_cnt | output | RETRY_W | Saturating local retry count |

## Verification
On every cycle, the assertions check the following: the channel is off during a global shutdown, discharge never overlaps an enabled channel, and soft-start pulses are single cycles. Restart strobes must come straight out of a shutdown, the retry count may change only with a soft-start pulse, and the fault flag stays set until a clear access. Only the bench scenarios can show the exact off-time and restart-delay lengths and the effect of the mask on the interrupt. The same holds for the read-to-clear and write-to-clear paths, counter saturation, and the fact that a short is ignored while the channel is off or already in shutdown.

// File: rtl/chan_ctl_pkg.sv
package chan_ctl_pkg;

   // configuration fields, most significant bit first
   typedef struct packed {
      logic       irq_mask;
      logic       local_retry;
      logic       dis_on_off;
      logic       phase_inv;
      logic [1:0] rate;
      logic       ovr_en;
      logic       ovr_ctl;
   } cfg_t;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HOFF = 2'd1,
      ST_GSHD = 2'd2
   } fsm_t;

endpackage

// File: rtl/chan_cfg_regs.sv
module chan_cfg_regs
   import chan_ctl_pkg::*;
#(
   parameter int          ADDR_W    = 8,
   parameter logic [7:0]  CFG_RESET = 8'hA0,
   parameter int          RETRY_W   = 6,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h45,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h46
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   input  logic              fault_evt,
   input  logic [RETRY_W-1:0] retry_cnt,
   output cfg_t              cfg,
   output logic              fault_flag,
   output logic              irq_n
);

   localparam int PAD_W = 7 - RETRY_W;

   logic hit_cfg, hit_stat, wr_cfg, clr_flag;
   logic [6:0] retry_ext;

   assign hit_cfg  = (addr == CFG_ADDR);
   assign hit_stat = (addr == STAT_ADDR);
   assign wr_cfg   = wr & hit_cfg;
   assign clr_flag = wr_cfg | (rd & hit_stat);

   generate
      if (PAD_W > 0) begin : g_pad
         assign retry_ext = {{PAD_W{1'b0}}, retry_cnt};
      end else begin : g_nopad
         assign retry_ext = retry_cnt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cfg <= cfg_t'(CFG_RESET);
      else if (wr_cfg) cfg <= cfg_t'(wdata);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         fault_flag <= 1'b0;
      else if (fault_evt) fault_flag <= 1'b1;
      else if (clr_flag)  fault_flag <= 1'b0;
   end

   always_comb begin
      rdata = 8'h00;
      if (hit_cfg)       rdata = cfg;
      else if (hit_stat) rdata = {retry_ext, fault_flag};
   end

   assign irq_n = ~(fault_flag & ~cfg.irq_mask);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(fault_flag) && !$past(clr_flag)) |-> fault_flag);

endmodule

// File: rtl/chan_en_mux.sv
module chan_en_mux
   import chan_ctl_pkg::*;
(
   input  cfg_t cfg,
   input  logic seq_en,
   input  logic fsm_run,
   output logic base_en,
   output logic chan_en,
   output logic dischg_en
);

   assign base_en   = cfg.ovr_ctl ? cfg.ovr_en : seq_en;
   assign chan_en   = base_en & fsm_run;
   assign dischg_en = cfg.dis_on_off & ~chan_en;

   always_comb begin
      p_dis_exclusive_r5: assert (!(chan_en && dischg_en));
   end

endmodule

// File: rtl/chan_fault_fsm.sv
module chan_fault_fsm
   import chan_ctl_pkg::*;
#(
   parameter int OFF_CYC     = 1000,
   parameter int RESTART_CYC = 10_000_000,
   parameter int RETRY_W     = 6,
   parameter bit RETRY_SAT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               base_en,
   input  logic               sc_in,
   input  logic               local_mode,
   output logic               run,
   output logic               glob_shdn,
   output logic               restart_req,
   output logic               softstart_req,
   output logic               fault_evt,
   output logic [RETRY_W-1:0] retry_cnt
);

   localparam int MAX_CYC = (OFF_CYC > RESTART_CYC) ? OFF_CYC : RESTART_CYC;
   localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
   localparam logic [CNT_W-1:0] OFF_LAST = CNT_W'(OFF_CYC - 1);
   localparam logic [CNT_W-1:0] RST_LAST = CNT_W'(RESTART_CYC - 1);

   fsm_t st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic hoff_done, gshd_done;
   logic [RETRY_W-1:0] retry_nx;

   assign fault_evt = (st_q == ST_RUN) & base_en & sc_in;
   assign hoff_done = (st_q == ST_HOFF) & (cnt_q == OFF_LAST);
   assign gshd_done = (st_q == ST_GSHD) & (cnt_q == RST_LAST);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN:  if (fault_evt) st_d = local_mode ? ST_HOFF : ST_GSHD;
         ST_HOFF: if (hoff_done) st_d = ST_RUN;
         ST_GSHD: if (gshd_done) st_d = ST_RUN;
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         cnt_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_d != st_q) cnt_q <= '0;
         else if (st_q != ST_RUN) cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         softstart_req <= 1'b0;
         restart_req   <= 1'b0;
      end else begin
         softstart_req <= hoff_done;
         restart_req   <= gshd_done;
      end
   end

   generate
      if (RETRY_SAT) begin : g_sat
         assign retry_nx = (&retry_cnt) ? retry_cnt : retry_cnt + 1'b1;
      end else begin : g_wrap
         assign retry_nx = retry_cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         retry_cnt <= '0;
      else if (hoff_done) retry_cnt <= retry_nx;
   end

   assign run       = (st_q == ST_RUN);
   assign glob_shdn = (st_q == ST_GSHD);

   p_ss_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      softstart_req |=> !softstart_req);
   p_restart_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(restart_req) |-> $past(glob_shdn));
   p_retry_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (retry_cnt != $past(retry_cnt)) |-> softstart_req);

endmodule

// File: rtl/chan_ctl_sup.sv
module chan_ctl_sup
   import chan_ctl_pkg::*;
#(
   parameter int         ADDR_W      = 8,
   parameter int         DATA_W      = 8,
   parameter logic [7:0] CFG_RESET   = 8'hA0,
   parameter logic [ADDR_W-1:0] CFG_ADDR  = 'h45,
   parameter logic [ADDR_W-1:0] STAT_ADDR = 'h46,
   parameter int         OFF_CYC     = 1000,
   parameter int         RESTART_CYC = 10_000_000,
   parameter int         RETRY_W     = 6,
   parameter bit         RETRY_SAT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic               seq_en,
   input  logic               sc_in,
   output logic               chan_en,
   output logic               dischg_en,
   output logic               phase_sel,
   output logic [1:0]         rate_code,
   output logic               irq_n,
   output logic               glob_shdn,
   output logic               restart_req,
   output logic               softstart_req,
   output logic [RETRY_W-1:0] retry_cnt
);

   generate
      if (DATA_W != 8) begin : g_bad_data
         $error("chan_ctl_sup: register width must be 8");
      end
      if (RETRY_W < 1 || RETRY_W > 7) begin : g_bad_retry
         $error("chan_ctl_sup: RETRY_W must be 1..7");
      end
      if (OFF_CYC < 1 || RESTART_CYC < 1) begin : g_bad_cyc
         $error("chan_ctl_sup: delays must be at least one cycle");
      end
      if (CFG_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("chan_ctl_sup: register addresses collide");
      end
   endgenerate

   cfg_t cfg;
   logic fault_flag, fault_evt, base_en, fsm_run;

   chan_cfg_regs #(
      .ADDR_W(ADDR_W), .CFG_RESET(CFG_RESET), .RETRY_W(RETRY_W),
      .CFG_ADDR(CFG_ADDR), .STAT_ADDR(STAT_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
      .wdata(bus_wdata), .rdata(bus_rdata), .fault_evt(fault_evt),
      .retry_cnt(retry_cnt), .cfg(cfg), .fault_flag(fault_flag), .irq_n(irq_n)
   );

   chan_en_mux u_mux (
      .cfg(cfg), .seq_en(seq_en), .fsm_run(fsm_run),
      .base_en(base_en), .chan_en(chan_en), .dischg_en(dischg_en)
   );

   chan_fault_fsm #(
      .OFF_CYC(OFF_CYC), .RESTART_CYC(RESTART_CYC),
      .RETRY_W(RETRY_W), .RETRY_SAT(RETRY_SAT)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .base_en(base_en), .sc_in(sc_in),
      .local_mode(cfg.local_retry), .run(fsm_run), .glob_shdn(glob_shdn),
      .restart_req(restart_req), .softstart_req(softstart_req),
      .fault_evt(fault_evt), .retry_cnt(retry_cnt)
   );

   assign phase_sel = cfg.phase_inv;
   assign rate_code = cfg.rate;

   p_shdn_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      glob_shdn |-> !chan_en);
   p_flag_on_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en && sc_in) |=> fault_flag);

endmodule

// File: tb/chan_ctl_sup_test.sv
module chan_ctl_sup_test;
   localparam int OFFC = 5;
   localparam int RSTC = 20;
   localparam int RW   = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00, bus_rdata;
   logic bus_wr = 1'b0, bus_rd = 1'b0, seq_en = 1'b0, sc_in = 1'b0;
   logic chan_en, dischg_en, phase_sel, irq_n, glob_shdn, restart_req, softstart_req;
   logic [1:0] rate_code;
   logic [RW-1:0] retry_cnt;
   int errs = 0, checks = 0;
   bit done = 0;

   always #5 clk = ~clk;

   chan_ctl_sup #(.OFF_CYC(OFFC), .RESTART_CYC(RSTC), .RETRY_W(RW)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .seq_en(seq_en), .sc_in(sc_in), .chan_en(chan_en), .dischg_en(dischg_en),
      .phase_sel(phase_sel), .rate_code(rate_code), .irq_n(irq_n),
      .glob_shdn(glob_shdn), .restart_req(restart_req),
      .softstart_req(softstart_req), .retry_cnt(retry_cnt));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [7:0] d);
      bus_addr = a; bus_rd = 1'b1; #1;
      d = bus_rdata;
      tick();
      bus_rd = 1'b0;
   endtask

   function automatic logic exp_en(input logic [7:0] c, input logic s);
      return c[0] ? c[1] : s;
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         errs++; checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] d, c, other;
      void'($urandom(32'd1234));
      #22 rst_n = 1'b1; #1;
      // R1 reset state
      rd_reg(8'h45, d); chk("R1 cfg reset", d, 8'hA0);
      rd_reg(8'h46, d); chk("R1 status reset", d, 8'h00);
      chk("R1 irq_n", irq_n, 1);
      chk("R1 idle strobes", {glob_shdn, restart_req, softstart_req}, 0);

      // R2..R5 random configurations, no fault
      for (int i = 0; i < 40; i++) begin
         c = 8'($urandom);
         seq_en = 1'($urandom);
         wr_reg(8'h45, c);
         rd_reg(8'h45, d); chk("R2 readback", d, c);
         chk("R3 enable", chan_en, exp_en(c, seq_en));
         seq_en = ~seq_en; #1;
         chk("R3 enable toggled seq", chan_en, exp_en(c, seq_en));
         chk("R4 phase", phase_sel, c[4]);
         chk("R4 rate", rate_code, c[3:2]);
         chk("R5 discharge", dischg_en, c[5] & ~exp_en(c, seq_en));
         chk("R7 irq idle", irq_n, 1);
         other = 8'($urandom);
         if (other == 8'h45 || other == 8'h46) other = 8'h10;
         wr_reg(other, ~c);
         rd_reg(8'h45, d); chk("R2 other address ignored", d, c);
      end

      // R11 short while channel off
      seq_en = 1'b0;
      wr_reg(8'h45, 8'h20);
      sc_in = 1'b1; tick(); tick(); sc_in = 1'b0;
      chk("R11 no shutdown", glob_shdn, 0);
      rd_reg(8'h46, d); chk("R11 no flag", d[0], 0);

      // R8 local retry
      wr_reg(8'h45, 8'h63);
      chk("R8 on before", chan_en, 1);
      sc_in = 1'b1; tick(); sc_in = 1'b0;
      chk("R8 off", chan_en, 0);
      chk("R6 irq set", irq_n, 0);
      chk("R5 discharge during off", dischg_en, 1);
      for (int k = 1; k < OFFC; k++) begin
         tick();
         chk("R8 still off", {chan_en, softstart_req, glob_shdn}, 3'b000);
      end
      tick();
      chk("R8 back on", chan_en, 1);
      chk("R8 softstart pulse", softstart_req, 1);
      chk("R8 retry inc", retry_cnt, 1);
      tick();
      chk("R8 pulse ends", softstart_req, 0);

      // R6 sticky and read clear
      tick(); tick();
      chk("R6 irq sticky", irq_n, 0);
      rd_reg(8'h46, d); chk("R6 status read", d, 8'h03);
      chk("R6 read cleared", irq_n, 1);
      rd_reg(8'h46, d); chk("R6 flag clear", d[0], 0);

      // R9 repeated retries saturate
      sc_in = 1'b1;
      for (int k = 0; k < 10 * (OFFC + 1); k++) begin
         tick();
         if (glob_shdn) chk("R9 no global", glob_shdn, 0);
      end
      sc_in = 1'b0;
      repeat (OFFC + 2) tick();
      chk("R9 saturated", retry_cnt, 7);
      chk("R9 recovered", chan_en, 1);

      // R7 mask: flag recorded, irq stays high; write clears flag
      wr_reg(8'h45, 8'hE3);
      sc_in = 1'b1; tick(); sc_in = 1'b0;
      chk("R7 masked irq", irq_n, 1);
      repeat (OFFC + 1) tick();
      bus_addr = 8'h46; #1; chk("R7 flag recorded", bus_rdata[0], 1);
      wr_reg(8'h45, 8'h63);
      bus_addr = 8'h46; #1; chk("R6 write cleared", bus_rdata[0], 0);

      // R10 global shutdown
      wr_reg(8'h45, 8'h23);
      sc_in = 1'b1; tick();
      chk("R10 shutdown", glob_shdn, 1);
      chk("R10 off", chan_en, 0);
      for (int k = 1; k < RSTC; k++) begin
         if (k == RSTC - 1) sc_in = 1'b0;
         tick();
         chk("R10 held", {glob_shdn, chan_en, restart_req}, 3'b100);
      end
      tick();
      chk("R10 released", {glob_shdn, chan_en, restart_req}, 3'b011);
      tick();
      chk("R10 strobe ends", restart_req, 0);
      chk("R10 no retry count", retry_cnt, 7);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule